// File: doc/BRIEF.md
# Framebuffer Line Unpacker

The block turns the raw bytes of a framebuffer line into a stream of pixels, one per cycle. Bytes arrive in address order on a valid/ready input. Depending on the selected depth, each pixel is either a palette index (1, 2, 4 or 8 bits per pixel) or a direct colour (16 or 32 bits per pixel) expanded to three 8-bit channels. Configuration inputs choose the byte order inside multi-byte pixels, the order of pixels packed inside a byte, and whether the red and blue channels trade places.

Alongside the pixel path, the block keeps the start address of the current row. A frame-start pulse loads it from the frame base address, folding the upper half of the address space back onto low memory. Each completed line advances it by the number of bytes that line occupies, and that byte count is presented continuously so a fetch unit can size its requests. Palette lookup, memory arbitration and display timing are handled elsewhere.

Top module: `fb_line_unpacker`

## Requirements
- R1: `cfg_depth` codes 0,1,2,3,4,5 select 1,2,4,8,16,32 bits per pixel; `line_bytes` equals `line_px` shifted right by 3,2,1, unchanged, shifted left by 1, shifted left by 2 for those codes respectively, and 0 for codes 6 and 7.
- R2: For depths of 8 bits or fewer each byte yields 8/bpp pixels output as `px_index`=1 with the index in `px_data[7:0]` and zero above; with the pixel order little (`cfg_pix_be`=0 and `cfg_byte_be`=0) the leftmost pixel is the least significant field of the byte, otherwise the most significant field.
- R3: At 16 bits per pixel two bytes form a value whose bits [4:0], [9:5], [14:10] are the three 5-bit fields (bit 15 ignored); with `cfg_swap`=0 they become red, green, blue, each shifted left by 3, output as `px_data` = {red, green, blue} with `px_index`=0.
- R4: At 32 bits per pixel four bytes form a value whose bits [7:0], [15:8], [23:16] are red, green, blue when `cfg_swap`=0 (bits [31:24] ignored), output as {red, green, blue}.
- R5: `cfg_swap`=1 exchanges the red and blue channels of direct-colour pixels.
- R6: With `cfg_byte_be`=0 the first byte of a pixel is its least significant byte; with `cfg_byte_be`=1 it is the most significant and sub-byte pixel order is also big; `cfg_pix_be` alone changes only the sub-byte order, so `cfg_byte_be` takes precedence when both are set.
- R7: Each time the last pixel of a line is accepted, `row_addr` increases by `line_bytes`.
- R8: A `frame_start` pulse loads `row_addr` with `base_addr`, minus 0x80000000 when `base_addr` is strictly greater than 0x80000000; 0x80000000 itself is kept.
- R9: Unless `cfg_enable` and `cfg_power` are both 1, `in_ready` and `px_valid` stay 0 and partially gathered data is discarded; after reset both are 0 and `row_addr` is 0.
- R10: `px_last` is 1 exactly on the pixel whose position within the line is `line_px`-1.
- R11: A pixel offered with `px_ready`=0 is offered again unchanged on the following cycle.
- R12: Depth codes 6 and 7 accept no bytes and produce no pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Controller enable |
| cfg_power | input | 1 | Panel power; both this and cfg_enable must be 1 |
| cfg_depth | input | 3 | Bits-per-pixel code |
| cfg_swap | input | 1 | Exchange red and blue |
| cfg_byte_be | input | 1 | Big byte order (also big pixel order) |
| cfg_pix_be | input | 1 | Big pixel order within a byte |
| frame_start | input | 1 | Restart at the frame base |
| base_addr | input | ADDR_W | Frame base address |
| line_px | input | WID_W | Pixels per line |
| in_valid | input | 1 | Byte available |
| in_ready | output | 1 | Byte accepted this cycle when in_valid |
| in_data | input | 8 | Framebuffer byte |
| px_valid | output | 1 | Pixel available |
| px_ready | input | 1 | Downstream takes the pixel |
| px_data | output | 24 | Index in [7:0], or {red, green, blue} |
| px_index | output | 1 | px_data holds a palette index |
| px_last | output | 1 | Final pixel of the line |
| row_addr | output | ADDR_W | Start address of the current row |
| line_bytes | output | WID_W+2 | Bytes occupied by one line |

## Verification
The assertions take for granted that the configuration inputs and `line_px` hold still during a line, that `line_px` is at least 1, and that for sub-byte depths it is a multiple of the pixels per byte so every line starts on a byte boundary. The stimulus changes configuration only between lines, around a `frame_start` pulse, draws widths as multiples of eight, and feeds exactly the bytes each line needs while randomising the input valid and output ready so both stalls and back-to-back transfers occur.

// File: rtl/fb_line_unpacker.sv
module fb_line_unpacker #(
  parameter int ADDR_W = 32,
  parameter int WID_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_power,
  input  logic [2:0]        cfg_depth,
  input  logic              cfg_swap,
  input  logic              cfg_byte_be,
  input  logic              cfg_pix_be,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [WID_W-1:0]  line_px,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [23:0]       px_data,
  output logic              px_index,
  output logic              px_last,
  output logic [ADDR_W-1:0] row_addr,
  output logic [WID_W+1:0]  line_bytes
);
  localparam int LBW = WID_W + 2;
  localparam logic [ADDR_W-1:0] ALIAS = {1'b1, {(ADDR_W-1){1'b0}}};

  logic [31:0]      buf_q;
  logic [2:0]       bcnt;
  logic [2:0]       sub;
  logic             full;
  logic [WID_W-1:0] pix_cnt;

  logic run, pix_be, take, fire, indexed;
  logic [2:0] need, last_sub;
  logic [3:0] bpp_w, ppb, sub_lo, sh;
  logic [7:0] pix_byte, mask8, idx;
  logic [14:0] v15;
  logic [7:0] f_lo, f_mid, f_hi, red, grn, blu;
  logic [ADDR_W-1:0] adj_base;

  assign run     = cfg_enable & cfg_power & (cfg_depth <= 3'd5);
  assign pix_be  = cfg_byte_be | cfg_pix_be;
  assign indexed = cfg_depth <= 3'd3;
  assign need    = (cfg_depth == 3'd4) ? 3'd2 : (cfg_depth == 3'd5) ? 3'd4 : 3'd1;
  assign bpp_w   = indexed ? (4'd1 << cfg_depth) : 4'd8;
  assign ppb     = indexed ? (4'd8 >> cfg_depth) : 4'd1;
  assign last_sub = 3'(ppb - 4'd1);

  assign in_ready = run & ~full;
  assign px_valid = run & full;
  assign take     = in_valid & in_ready;
  assign fire     = px_valid & px_ready;
  assign px_last  = px_valid & (pix_cnt == WID_W'(line_px - 1'b1));
  assign px_index = indexed;

  always_comb begin
    case (cfg_depth)
      3'd0: line_bytes = LBW'(line_px >> 3);
      3'd1: line_bytes = LBW'(line_px >> 2);
      3'd2: line_bytes = LBW'(line_px >> 1);
      3'd3: line_bytes = LBW'(line_px);
      3'd4: line_bytes = {1'b0, line_px, 1'b0};
      3'd5: line_bytes = {line_px, 2'b00};
      default: line_bytes = '0;
    endcase
  end

  assign pix_byte = cfg_byte_be ? buf_q[7:0] : buf_q[31:24];
  assign sub_lo   = 4'(sub) * bpp_w;
  assign sh       = pix_be ? 4'(4'd8 - sub_lo - bpp_w) : sub_lo;
  assign mask8    = 8'((9'd1 << bpp_w) - 9'd1);
  assign idx      = (pix_byte >> sh) & mask8;

  assign v15 = cfg_byte_be ? buf_q[14:0] : buf_q[30:16];

  always_comb begin
    if (cfg_depth == 3'd4) begin
      f_lo  = {v15[4:0], 3'b000};
      f_mid = {v15[9:5], 3'b000};
      f_hi  = {v15[14:10], 3'b000};
    end else begin
      f_lo  = buf_q[7:0];
      f_mid = buf_q[15:8];
      f_hi  = buf_q[23:16];
    end
    red = cfg_swap ? f_hi : f_lo;
    blu = cfg_swap ? f_lo : f_hi;
    grn = f_mid;
    px_data = indexed ? {16'h0000, idx} : {red, grn, blu};
  end

  assign adj_base = (base_addr > ALIAS) ? (base_addr - ALIAS) : base_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_addr <= '0;
    end else if (frame_start) begin
      row_addr <= adj_base;
    end else if (fire && px_last) begin
      row_addr <= row_addr + ADDR_W'(line_bytes);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= '0;
      bcnt    <= '0;
      sub     <= '0;
      full    <= 1'b0;
      pix_cnt <= '0;
    end else if (!run || frame_start) begin
      bcnt    <= '0;
      sub     <= '0;
      full    <= 1'b0;
      pix_cnt <= '0;
    end else begin
      if (take) begin
        buf_q <= cfg_byte_be ? {buf_q[23:0], in_data} : {in_data, buf_q[31:8]};
        if (bcnt + 3'd1 == need) begin
          full <= 1'b1;
          bcnt <= '0;
          sub  <= '0;
        end else begin
          bcnt <= bcnt + 3'd1;
        end
      end
      if (fire) begin
        if (px_last) begin
          pix_cnt <= '0;
          full    <= 1'b0;
        end else begin
          pix_cnt <= pix_cnt + 1'b1;
          if (sub == last_sub) full <= 1'b0;
          else sub <= sub + 3'd1;
        end
      end
    end
  end

  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_enable && cfg_power) |=> !px_valid);

  a_r11_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready && !frame_start) |=> (px_valid || !run));

  a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && px_last && !frame_start) |=>
      row_addr == $past(row_addr) + ADDR_W'($past(line_bytes)));

  a_r8_base_folded: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> row_addr <= ALIAS);

  a_r2_pixel_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(take));

endmodule

// File: tb/fb_line_unpacker_bench.sv
module fb_line_unpacker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 0, cfg_power = 0, cfg_swap = 0, cfg_byte_be = 0, cfg_pix_be = 0;
  logic [2:0] cfg_depth = 0;
  logic frame_start = 0;
  logic [31:0] base_addr = 0;
  logic [10:0] line_px = 11'd8;
  logic in_valid = 0, px_ready = 0;
  logic [7:0] in_data = 0;
  logic in_ready, px_valid, px_index, px_last;
  logic [23:0] px_data;
  logic [31:0] row_addr;
  logic [12:0] line_bytes;

  int nchk = 0, nfail = 0;
  logic [7:0] mem [0:1023];

  always #4 clk = ~clk;

  fb_line_unpacker u_fb_line_unpacker (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_power(cfg_power),
    .cfg_depth(cfg_depth), .cfg_swap(cfg_swap), .cfg_byte_be(cfg_byte_be),
    .cfg_pix_be(cfg_pix_be), .frame_start(frame_start), .base_addr(base_addr),
    .line_px(line_px), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .px_valid(px_valid), .px_ready(px_ready), .px_data(px_data), .px_index(px_index),
    .px_last(px_last), .row_addr(row_addr), .line_bytes(line_bytes));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fold(input logic [31:0] b);
    return (b > 32'h8000_0000) ? b - 32'h8000_0000 : b;
  endfunction

  function automatic int lbytes(input int code, input int w);
    case (code)
      0: return w / 8;
      1: return w / 4;
      2: return w / 2;
      3: return w;
      4: return w * 2;
      5: return w * 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [23:0] exp_px(input int pi, input int w);
    int code = int'(cfg_depth);
    int l = pi / w, x = pi % w;
    int o = l * lbytes(code, w);
    logic [7:0] b0, b1, b2, b3, r, g, bl, lo, hi;
    logic [31:0] v;
    if (code <= 3) begin
      int bpp = 1 << code;
      int ppb = 8 / bpp;
      int s = x % ppb;
      int sh = (cfg_byte_be || cfg_pix_be) ? 8 - (s + 1) * bpp : s * bpp;
      b0 = mem[o + x / ppb];
      return {16'h0, 8'((b0 >> sh) & ((1 << bpp) - 1))};
    end
    if (code == 4) begin
      b0 = mem[o + 2*x]; b1 = mem[o + 2*x + 1];
      v = cfg_byte_be ? {16'h0, b0, b1} : {16'h0, b1, b0};
      lo = {v[4:0], 3'b0}; g = {v[9:5], 3'b0}; hi = {v[14:10], 3'b0};
    end else begin
      b0 = mem[o + 4*x]; b1 = mem[o + 4*x + 1]; b2 = mem[o + 4*x + 2]; b3 = mem[o + 4*x + 3];
      v = cfg_byte_be ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
      lo = v[7:0]; g = v[15:8]; hi = v[23:16];
    end
    r  = cfg_swap ? hi : lo;
    bl = cfg_swap ? lo : hi;
    return {r, g, bl};
  endfunction

  task automatic setup(input int code, input bit sw, input bit bbe, input bit pbe,
                       input int w, input logic [31:0] b);
    @(negedge clk);
    cfg_enable = 1; cfg_power = 1; cfg_depth = 3'(code);
    cfg_swap = sw; cfg_byte_be = bbe; cfg_pix_be = pbe;
    line_px = 11'(w); base_addr = b; frame_start = 1;
    in_valid = 0; px_ready = 0;
    @(negedge clk);
    frame_start = 0;
  endtask

  task automatic run_lines(input string tag, input int code, input bit sw, input bit bbe,
                           input bit pbe, input int w, input logic [31:0] b,
                           input int lines, input int vp, input int rp);
    int lb, total, bi, pi, cyc;
    bit held;
    logic [23:0] hd;
    setup(code, sw, bbe, pbe, w, b);
    lb = lbytes(code, w);
    #1;
    chk(line_bytes == 13'(lb), "R1", "line_bytes", 32'(line_bytes), lb);
    chk(row_addr == fold(b), "R8", "row_addr after frame_start", row_addr, fold(b));
    total = lines * lb;
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
    bi = 0; pi = 0; cyc = 0; held = 0; hd = '0;
    while (pi < lines * w && cyc < 20000) begin
      @(negedge clk);
      in_valid = (bi < total) && (($urandom % 100) < vp);
      in_data  = mem[bi];
      px_ready = ($urandom % 100) < rp;
      #3;
      if (held) begin
        chk(px_valid && px_data == hd, "R11", "stalled pixel held", px_data, hd);
        held = 0;
      end
      if (in_valid && in_ready) bi++;
      if (px_valid) begin
        if (px_ready) begin
          logic [23:0] e = exp_px(pi, w);
          chk(px_data == e, tag, "pixel data", px_data, e);
          chk(px_index == (code <= 3), "R2", "px_index", px_index, code <= 3);
          chk(px_last == ((pi % w) == w - 1), "R10", "px_last", px_last, (pi % w) == w - 1);
          pi++;
        end else begin
          held = 1; hd = px_data;
        end
      end
      cyc++;
    end
    chk(pi == lines * w, tag, "pixel count", pi, lines * w);
    @(negedge clk);
    in_valid = 0; px_ready = 0;
    #3;
    chk(row_addr == fold(b) + 32'(lines * lb), "R7", "row_addr after lines",
        row_addr, fold(b) + 32'(lines * lb));
  endtask

  task automatic quiet(input string tag, input bit en, input bit pw, input int code);
    bit bad = 0;
    @(negedge clk);
    cfg_enable = en; cfg_power = pw; cfg_depth = 3'(code);
    in_valid = 1; in_data = 8'hA5; px_ready = 1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      #3;
      if (in_ready || px_valid) bad = 1;
    end
    chk(!bad, tag, "no transfer while idle", {in_ready, px_valid}, 0);
    @(negedge clk);
    in_valid = 0; px_ready = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #3;
    chk(!px_valid && !in_ready, "R9", "reset outputs", {px_valid, in_ready}, 0);
    chk(row_addr == 0, "R9", "reset row_addr", row_addr, 0);
    @(negedge clk);
    rst_n = 1;

    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      cfg_depth = 3'(c); line_px = 11'd64;
      #1;
      chk(line_bytes == 13'(lbytes(c, 64)), "R1", "line_bytes per code", 32'(line_bytes), lbytes(c, 64));
    end

    run_lines("R2", 0, 0, 0, 0, 16, 32'h0000_1000, 2, 100, 100);
    run_lines("R2", 0, 0, 0, 1, 16, 32'h0000_1000, 2, 100, 100);
    run_lines("R2", 1, 0, 1, 0, 24, 32'h0000_2000, 2, 70, 60);
    run_lines("R2", 2, 0, 0, 1, 16, 32'h0000_2000, 2, 70, 60);
    run_lines("R2", 3, 0, 0, 0, 16, 32'h0000_3000, 2, 90, 90);
    run_lines("R3", 4, 0, 0, 0, 16, 32'h0000_4000, 2, 80, 80);
    run_lines("R5", 4, 1, 0, 0, 16, 32'h0000_4000, 2, 80, 80);
    run_lines("R6", 4, 0, 0, 1, 16, 32'h0000_5000, 2, 80, 50);
    run_lines("R6", 4, 0, 1, 0, 16, 32'h0000_5000, 2, 80, 50);
    run_lines("R6", 5, 0, 1, 1, 8, 32'h0000_6000, 2, 80, 50);
    run_lines("R4", 5, 0, 0, 0, 8, 32'h0000_6000, 3, 80, 30);
    run_lines("R5", 5, 1, 0, 0, 8, 32'h0000_6000, 2, 80, 80);
    run_lines("R8", 3, 0, 0, 0, 8, 32'h8000_0000, 2, 100, 100);
    run_lines("R8", 3, 0, 0, 0, 8, 32'h8000_1000, 2, 100, 100);
    run_lines("R8", 2, 0, 0, 0, 8, 32'hFFFF_FFF0, 2, 100, 100);

    quiet("R9", 0, 1, 3);
    quiet("R9", 1, 0, 4);
    quiet("R12", 1, 1, 6);
    quiet("R12", 1, 1, 7);

    void'($urandom(32'd20240611));
    for (int k = 0; k < 30; k++) begin
      int code = int'($urandom % 6);
      string tag = (code <= 3) ? "R2" : (code == 4) ? "R3" : "R4";
      run_lines(tag, code, 1'($urandom), 1'($urandom), 1'($urandom),
                8 * (1 + int'($urandom % 8)), $urandom, 2 + int'($urandom % 2),
                40 + int'($urandom % 61), 40 + int'($urandom % 61));
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(8 * 190000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule